// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Control

This combinational block steers the two ALU operands of the execute stage in a five-stage integer pipeline (fetch, decode, execute, memory, write-back). For each operand it compares the source register number held in the decode/execute pipeline register against the destination of the older instruction sitting in the memory stage and the one sitting in write-back. When a producer will write a register, is not aimed at register zero, and names the same register, the block selects a bypass path instead of the register-file value.

It also watches for a load sitting in execute whose destination is read by the instruction now in decode. Such a value cannot be bypassed in time, so the block deasserts the write enable of the program counter and the fetch/decode register and raises a bubble request. The pipeline turns that request into a no-op by clearing the register-write and memory-write control bits it loads into the decode/execute register. Branch resolution and flushing belong elsewhere. All pins are plain control signals with no handshake; outputs follow inputs in the same cycle.

Top module: `fwd_hazard_unit`

## Requirements
- R1: With no qualifying producer match, an operand select is 2'b00 (register-file value).
- R2: A memory-stage producer (write flag high, destination nonzero) whose destination equals an execute source sets that operand's select to 2'b10.
- R3: A write-back producer (write flag high, destination nonzero) matching an execute source, with no memory-stage match on that source, sets the select to 2'b01.
- R4: When both producers match the same source, the select is 2'b10: the memory-stage value is the newer one.
- R5: A destination of register zero never produces forwarding, even with its write flag high.
- R6: A producer whose write flag is low (for example a store) never produces forwarding.
- R7: Operand A (fwd_a, from ex_rs1) and operand B (fwd_b, from ex_rs2) are decided independently and may pick different sources in one cycle.
- R8: A load in execute (ex_load high) whose nonzero destination equals id_rs1 or id_rs2 drives pc_if_we low and id_ex_bubble high.
- R9: Without a load in execute, or with a load to register zero, or with no source match, pc_if_we is high and id_ex_bubble is low.
- R10: pc_if_we is always the inverse of id_ex_bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | 5 | First source register of the instruction in execute |
| ex_rs2 | input | 5 | Second source register of the instruction in execute |
| id_rs1 | input | 5 | First source register of the instruction in decode |
| id_rs2 | input | 5 | Second source register of the instruction in decode |
| ex_rd | input | 5 | Destination of the instruction in execute |
| ex_load | input | 1 | Instruction in execute reads data memory |
| mem_rd | input | 5 | Destination of the instruction in the memory stage |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination of the instruction in write-back |
| wb_we | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Operand A select: 00 register file, 01 write-back, 10 memory stage |
| fwd_b | output | 2 | Operand B select, same encoding |
| pc_if_we | output | 1 | Write enable for PC and fetch/decode register (low = hold) |
| id_ex_bubble | output | 1 | Request to load a no-op into decode/execute |

## Verification
The bench targets the double match where both older instructions write the same register; a design with the priority reversed would feed the stale write-back value and report 01. It drives register zero as a destination with the write flag high, which a design lacking the zero guard would bypass, and drives a matching store-like producer with its write flag low. It sends different matches to the two operands in one cycle to catch crossed or shared selects, and triggers load-use through each decode source separately and through a load to register zero, where a careless detector would stall needlessly.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output fwd_sel_e      sel
);
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = mem_we && (mem_rd != '0) && (mem_rd == src);
    wb_hit  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
    // newest producer takes precedence
    if (mem_hit)     sel = SEL_MEM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_REGFILE;
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int AW    = 5,
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0][AW-1:0] dec_src,
  input  logic [AW-1:0]            ld_rd,
  input  logic                     ld_valid,
  output logic                     stall
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
    assign hit[g] = (dec_src[g] == ld_rd);
  end

  assign stall = ld_valid && (ld_rd != '0) && (|hit);
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fwd_hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_if_we,
  output logic          id_ex_bubble
);
  localparam int N_OPS = 2;

  logic [N_OPS-1:0][AW-1:0] ex_src;
  logic [N_OPS-1:0][AW-1:0] id_src;
  fwd_sel_e                 sel [N_OPS];
  logic                     lu_stall;

  assign ex_src = {ex_rs2, ex_rs1};
  assign id_src = {id_rs2, id_rs1};

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fwd_operand_sel #(.AW(AW)) i_sel (
      .src    (ex_src[g]),
      .mem_rd (mem_rd),
      .mem_we (mem_we),
      .wb_rd  (wb_rd),
      .wb_we  (wb_we),
      .sel    (sel[g])
    );
  end

  load_use_detect #(.AW(AW), .N_SRC(N_OPS)) i_lu (
    .dec_src  (id_src),
    .ld_rd    (ex_rd),
    .ld_valid (ex_load),
    .stall    (lu_stall)
  );

  assign fwd_a        = sel[0];
  assign fwd_b        = sel[1];
  assign id_ex_bubble = lu_stall;
  assign pc_if_we     = ~lu_stall;
endmodule

// File: rtl/fwd_hazard_chk.sv
module fwd_hazard_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rs2,
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] id_rs2,
  input logic [AW-1:0] ex_rd,
  input logic          ex_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_we,
  input logic [AW-1:0] wb_rd,
  input logic          wb_we,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          pc_if_we,
  input logic          id_ex_bubble
);
  always_comb begin
    if (!$isunknown({ex_rs1, ex_rs2, id_rs1, id_rs2, ex_rd, ex_load,
                     mem_rd, mem_we, wb_rd, wb_we,
                     fwd_a, fwd_b, pc_if_we, id_ex_bubble})) begin
      // R4
      mem_prio_chk: assert (!(mem_we && mem_rd != '0 && mem_rd == ex_rs1) || fwd_a == 2'b10)
        else $error("memory-stage match on operand A not selected");
      // R5
      zero_dest_chk: assert (!(ex_rs1 == '0 && fwd_a != 2'b00) && !(ex_rs2 == '0 && fwd_b != 2'b00))
        else $error("register zero forwarded");
      // R6
      no_writer_chk: assert ((mem_we || wb_we) || (fwd_a == 2'b00 && fwd_b == 2'b00))
        else $error("forwarding without a register writer");
      // R8
      load_stall_chk: assert (!(ex_load && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2)) || id_ex_bubble)
        else $error("load-use not stalled");
      // R10
      hold_pair_chk: assert (pc_if_we != id_ex_bubble)
        else $error("hold and bubble disagree");
    end
  end
endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.AW(AW)) i_fwd_hazard_chk (
  .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .id_rs1(id_rs1), .id_rs2(id_rs2),
  .ex_rd(ex_rd), .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we),
  .wb_rd(wb_rd), .wb_we(wb_we), .fwd_a(fwd_a), .fwd_b(fwd_b),
  .pc_if_we(pc_if_we), .id_ex_bubble(id_ex_bubble)
);

// File: tb/test_fwd_hazard_unit.sv
module test_fwd_hazard_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [4:0] ex_rs1, ex_rs2, id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
  logic       ex_load, mem_we, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic       pc_if_we, id_ex_bubble;

  typedef struct {
    logic [1:0] a;
    logic [1:0] b;
    logic       stall;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_hazard_unit i_fwd_hazard_unit (
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rd(ex_rd), .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_if_we(pc_if_we), .id_ex_bubble(id_ex_bubble)
  );

  task automatic apply(input logic [4:0] ers1, input logic [4:0] ers2,
                       input logic [4:0] irs1, input logic [4:0] irs2,
                       input logic [4:0] erd,  input logic eld,
                       input logic [4:0] mrd,  input logic mwe,
                       input logic [4:0] wrd,  input logic wwe,
                       input logic [1:0] ea, input logic [1:0] eb,
                       input logic est, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    ex_rs1 = ers1; ex_rs2 = ers2; id_rs1 = irs1; id_rs2 = irs2;
    ex_rd = erd; ex_load = eld; mem_rd = mrd; mem_we = mwe;
    wb_rd = wrd; wb_we = wwe;
    e.a = ea; e.b = eb; e.stall = est; e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (fwd_a !== e.a || fwd_b !== e.b || id_ex_bubble !== e.stall || pc_if_we !== ~e.stall) begin
        n_fail++;
        $display("FAIL %s: got a=%b b=%b bubble=%b we=%b, expected a=%b b=%b bubble=%b we=%b",
                 e.tag, fwd_a, fwd_b, id_ex_bubble, pc_if_we, e.a, e.b, e.stall, ~e.stall);
      end
    end
  end

  initial begin
    ex_rs1 = '0; ex_rs2 = '0; id_rs1 = '0; id_rs2 = '0; ex_rd = '0;
    ex_load = 1'b0; mem_rd = '0; mem_we = 1'b0; wb_rd = '0; wb_we = 1'b0;
    //     ers1 ers2 irs1 irs2 erd ld  mrd we  wrd we   a      b      st
    apply(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 0, 5'd0, 0, 5'd0, 0, 2'b00, 2'b00, 0, "R1 idle");
    apply(5'd3, 5'd4, 5'd1, 5'd2, 5'd9, 0, 5'd7, 1, 5'd8, 1, 2'b00, 2'b00, 0, "R1 no match");
    apply(5'd7, 5'd4, 5'd1, 5'd2, 5'd9, 0, 5'd7, 1, 5'd8, 1, 2'b10, 2'b00, 0, "R2 mem on A");
    apply(5'd3, 5'd7, 5'd1, 5'd2, 5'd9, 0, 5'd7, 1, 5'd8, 1, 2'b00, 2'b10, 0, "R2 mem on B");
    apply(5'd8, 5'd8, 5'd1, 5'd2, 5'd9, 0, 5'd7, 1, 5'd8, 1, 2'b01, 2'b01, 0, "R3 wb on both");
    apply(5'd5, 5'd6, 5'd1, 5'd2, 5'd9, 0, 5'd5, 1, 5'd5, 1, 2'b10, 2'b00, 0, "R4 double match A");
    apply(5'd6, 5'd5, 5'd1, 5'd2, 5'd9, 0, 5'd5, 1, 5'd5, 1, 2'b00, 2'b10, 0, "R4 double match B");
    apply(5'd0, 5'd0, 5'd1, 5'd2, 5'd9, 0, 5'd0, 1, 5'd0, 1, 2'b00, 2'b00, 0, "R5 x0 dest");
    apply(5'd0, 5'd6, 5'd1, 5'd2, 5'd9, 0, 5'd0, 1, 5'd6, 1, 2'b00, 2'b01, 0, "R5 x0 mem with wb on B");
    apply(5'd7, 5'd8, 5'd1, 5'd2, 5'd9, 0, 5'd7, 0, 5'd8, 0, 2'b00, 2'b00, 0, "R6 no write flags");
    apply(5'd7, 5'd7, 5'd1, 5'd2, 5'd9, 0, 5'd7, 0, 5'd7, 1, 2'b01, 2'b01, 0, "R6 store in mem, wb wins");
    apply(5'd7, 5'd8, 5'd1, 5'd2, 5'd9, 0, 5'd7, 1, 5'd8, 1, 2'b10, 2'b01, 0, "R7 A mem B wb");
    apply(5'd8, 5'd7, 5'd1, 5'd2, 5'd9, 0, 5'd7, 1, 5'd8, 1, 2'b01, 2'b10, 0, "R7 A wb B mem");
    apply(5'd3, 5'd4, 5'd9, 5'd2, 5'd9, 1, 5'd0, 0, 5'd0, 0, 2'b00, 2'b00, 1, "R8 load on id_rs1");
    apply(5'd3, 5'd4, 5'd1, 5'd9, 5'd9, 1, 5'd0, 0, 5'd0, 0, 2'b00, 2'b00, 1, "R8 load on id_rs2");
    apply(5'd3, 5'd4, 5'd1, 5'd9, 5'd9, 0, 5'd0, 0, 5'd0, 0, 2'b00, 2'b00, 0, "R9 non-load match");
    apply(5'd3, 5'd4, 5'd0, 5'd0, 5'd0, 1, 5'd0, 0, 5'd0, 0, 2'b00, 2'b00, 0, "R9 load to x0");
    apply(5'd3, 5'd4, 5'd1, 5'd2, 5'd9, 1, 5'd0, 0, 5'd0, 0, 2'b00, 2'b00, 0, "R9 load no match");
    apply(5'd7, 5'd8, 5'd9, 5'd9, 5'd9, 1, 5'd7, 1, 5'd8, 1, 2'b10, 2'b01, 1, "R10 stall with forwarding");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule